// File: doc/BRIEF.md
# Cascadable Carrier Summation Output Stage

This block forms the last stage of a transmit datapath that may be chained across several identical devices. On each clock it adds a locally generated 18-bit two's-complement carrier sample to an 18-bit sample from the upstream device. It registers the result onto an 18-bit output bus. That bus feeds either the next device in the chain or a DAC. The first device in a chain has its cascade input tied to zero.

On an intermediate device, clipping and offset-binary handling stay off. The top output bit then carries the sum as a guard bit, so a partial sum may exceed full scale without loss. On the device that drives the DAC, three static inputs shape the output. The first selects which output bit serves as the DAC MSB, which sets the maximum single-carrier level. The second turns bit 17 into a clip flag and saturates the data bits. The third converts the data to offset binary, either by inverting the DAC MSB or by adding a fixed compensation constant.

Top module: `csum_out_stage`

## Requirements
- R1: The output bus is registered and has one clock cycle of latency from the inputs. While rst_ni is low the output is 0.
- R2: With clip_en_i=0 and obin_en_i=0, out_o equals (carrier_i + cascade_i) modulo 2^18. Bit 17 carries the guard bit of the sum.
- R3: map_sel_i selects the DAC MSB bit position P as follows: 0 gives bit 17 (−12.04 dB), 1 gives bit 16 (−6.02 dB), 2 gives bit 15 (0 dB) and 3 gives bit 14 (+6.02 dB). The DAC full-scale range is [−2^P, 2^P−1].
- R4: With clip_en_i=1 and map_sel_i=1, out_o[17] is 1 exactly when the sum is above 2^16−1 or below −2^16. Without a clip, out_o[16:0] is the sum's bits 16..0.
- R5: With clip_en_i=1 and map_sel_i of 2 or 3, only positive overflow (sum > 2^P−1) sets out_o[17]. A negative sum never sets it, and out_o[16:0] is then the sum's bits 16..0.
- R6: When a clip is flagged, out_o[16:0] is the saturated value in 17-bit two's complement. That value is 2^P−1 for positive overflow and −2^P for negative overflow.
- R7: With map_sel_i=0, clip_en_i has no effect and the output is the same as in R2.
- R8: With obin_en_i=1 and map_sel_i of 0 or 1, bit P of the word after the clip stage is inverted.
- R9: With obin_en_i=1, map_sel_i=2 adds 0x08000 to out_o[16:0], and map_sel_i=3 adds 0x0C000. Both additions are modulo 2^17, and out_o[17] is unchanged.
- R10: Clip decisions use the full-precision 19-bit sum, so the sum of two full-scale negative inputs (−2^18) counts as negative overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 18 | Local carrier sample, two's complement |
| cascade_i | input | 18 | Upstream cascade sample, two's complement |
| clip_en_i | input | 1 | Turns bit 17 into a clip flag and saturates the data bits |
| obin_en_i | input | 1 | Enables offset-binary conversion |
| map_sel_i | input | 2 | Selects the DAC MSB bit position (R3) |
| out_o | output | 18 | Registered output bus |

## Verification
Clip saturation and offset-binary conversion can both act on the same sample: a flagged clip produces a saturated word, and the offset stage then transforms that word before it is registered. The bench drives overflowing sums with both enables set, in both the bit-inversion maps and the constant-addition maps. It compares the output against hand-derived words in which the clip flag is kept and only the saturated data bits are converted. Boundary sums exactly at −2^P and 2^P−1 are included, to confirm that the flag is not raised one step early.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic [1:0] {
    MAP_B17 = 2'd0,
    MAP_B16 = 2'd1,
    MAP_B15 = 2'd2,
    MAP_B14 = 2'd3
  } map_sel_e;

  localparam int NUM_MAPS = 4;
endpackage

// File: rtl/csum_adder.sv
module csum_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic signed [W:0] sum_o
);
  always_comb sum_o = $signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i});
endmodule

// File: rtl/csum_clip.sv
module csum_clip #(
  parameter int W = 18
) (
  input  logic signed [W:0] sum_i,
  input  logic              clip_en_i,
  input  logic [1:0]        map_sel_i,
  output logic [W-1:0]      word_o
);
  import csum_pkg::*;
  localparam int SW = W + 1;

  logic [W-1:0] cand [NUM_MAPS];

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    localparam int P = W - 1 - g;
    localparam logic signed [SW-1:0] MAXV = SW'((64'd1 << P) - 64'd1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
    logic pos_ovf, neg_ovf;
    always_comb begin
      pos_ovf = sum_i > MAXV;
      neg_ovf = sum_i < MINV;
    end
    if (g == 0) begin : g_none
      // clip is not applicable when the DAC MSB is bit W-1
      always_comb cand[g] = sum_i[W-1:0];
      logic unused_ovf;
      always_comb unused_ovf = pos_ovf ^ neg_ovf ^ clip_en_i;
    end else if (g == 1) begin : g_both
      always_comb begin
        if (clip_en_i && pos_ovf)      cand[g] = {1'b1, MAXV[W-2:0]};
        else if (clip_en_i && neg_ovf) cand[g] = {1'b1, MINV[W-2:0]};
        else if (clip_en_i)            cand[g] = {1'b0, sum_i[W-2:0]};
        else                           cand[g] = sum_i[W-1:0];
      end
    end else begin : g_pos
      logic unused_neg;
      always_comb unused_neg = neg_ovf;
      always_comb begin
        if (clip_en_i && pos_ovf) cand[g] = {1'b1, MAXV[W-2:0]};
        else if (clip_en_i)       cand[g] = {1'b0, sum_i[W-2:0]};
        else                      cand[g] = sum_i[W-1:0];
      end
    end
  end

  always_comb word_o = cand[map_sel_i];
endmodule

// File: rtl/csum_offset.sv
module csum_offset #(
  parameter int W = 18
) (
  input  logic [W-1:0] word_i,
  input  logic         obin_en_i,
  input  logic [1:0]   map_sel_i,
  output logic [W-1:0] word_o
);
  import csum_pkg::*;

  logic [W-1:0] cand [NUM_MAPS];

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    localparam int P = W - 1 - g;
    if (g < 2) begin : g_inv
      localparam logic [W-1:0] MASK = W'(64'd1 << P);
      always_comb cand[g] = obin_en_i ? (word_i ^ MASK) : word_i;
    end else begin : g_add
      // compensation constant: bit P plus every bit from P up to W-3
      localparam logic [W-2:0] OFS = (W-1)'((64'd1 << (W-2)) - (64'd1 << P));
      always_comb cand[g] = obin_en_i ? {word_i[W-1], word_i[W-2:0] + OFS} : word_i;
    end
  end

  always_comb word_o = cand[map_sel_i];
endmodule

// File: rtl/csum_out_stage.sv
module csum_out_stage #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] carrier_i,
  input  logic [W-1:0] cascade_i,
  input  logic         clip_en_i,
  input  logic         obin_en_i,
  input  logic [1:0]   map_sel_i,
  output logic [W-1:0] out_o
);
  logic signed [W:0] sum_w;
  logic [W-1:0]      clip_w, conv_w, out_q;

  csum_adder  #(.W(W)) u_add (.a_i(carrier_i), .b_i(cascade_i), .sum_o(sum_w));
  csum_clip   #(.W(W)) u_clip (.sum_i(sum_w), .clip_en_i(clip_en_i),
                               .map_sel_i(map_sel_i), .word_o(clip_w));
  csum_offset #(.W(W)) u_ofs (.word_i(clip_w), .obin_en_i(obin_en_i),
                              .map_sel_i(map_sel_i), .word_o(conv_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= conv_w;
  end

  assign out_o = out_q;

  // checks relating ports across one cycle
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic [W-1:0]      chk_trunc;
  logic signed [W:0] chk_wide;
  localparam logic signed [W:0] B16_MAX = (W+1)'((64'd1 << (W-2)) - 64'd1);
  localparam logic signed [W:0] B16_MIN = -B16_MAX - (W+1)'(1);
  always_comb begin
    chk_trunc = carrier_i + cascade_i;
    chk_wide  = $signed({carrier_i[W-1], carrier_i}) + $signed({cascade_i[W-1], cascade_i});
  end

  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!clip_en_i && !obin_en_i) |-> out_o == $past(chk_trunc));

  a_r4_flag_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(clip_en_i && !obin_en_i && map_sel_i == 2'd1)
    |-> out_o[W-1] == $past(chk_wide > B16_MAX || chk_wide < B16_MIN));

  a_r5_pos_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(clip_en_i && map_sel_i[1]) && out_o[W-1]
    |-> $past(chk_wide) > 0);

  a_r7_no_clip_b17: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(map_sel_i == 2'd0 && !obin_en_i) |-> out_o == $past(chk_trunc));

  a_r9_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(obin_en_i && !clip_en_i && map_sel_i[1])
    |-> out_o[W-1] == $past(chk_trunc[W-1]));
endmodule

// File: tb/tb_csum_out_stage.sv
module tb_csum_out_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] carrier_i = '0, cascade_i = '0;
  logic        clip_en_i = 1'b0, obin_en_i = 1'b0;
  logic [1:0]  map_sel_i = 2'd0;
  logic [17:0] out_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  csum_out_stage dut (.*);

  always #4 clk_i = ~clk_i;

  // {req(4), carrier(18), cascade(18), clip, obin, sel(2), expected(18)}
  localparam int NV = 20;
  localparam logic [61:0] VEC [NV] = '{
    {4'd2,  18'h00100, 18'h00200, 1'b0, 1'b0, 2'd0, 18'h00300}, // R2
    {4'd2,  18'h1FFFF, 18'h00001, 1'b0, 1'b0, 2'd0, 18'h20000}, // R2 guard bit
    {4'd2,  18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 2'd1, 18'h3FFFE}, // R2 negative
    {4'd4,  18'h0EA60, 18'h02710, 1'b1, 1'b0, 2'd1, 18'h2FFFF}, // R4 R6 pos clip
    {4'd4,  18'h315A0, 18'h3D8F0, 1'b1, 1'b0, 2'd1, 18'h30000}, // R4 R6 neg clip
    {4'd4,  18'h0FFFF, 18'h00000, 1'b1, 1'b0, 2'd1, 18'h0FFFF}, // R4 top edge
    {4'd4,  18'h30000, 18'h00000, 1'b1, 1'b0, 2'd1, 18'h10000}, // R4 bottom edge
    {4'd5,  18'h08000, 18'h00000, 1'b1, 1'b0, 2'd2, 18'h27FFF}, // R5 R3 bit15
    {4'd5,  18'h07FFF, 18'h00000, 1'b1, 1'b0, 2'd2, 18'h07FFF}, // R5 edge
    {4'd5,  18'h363C0, 18'h00000, 1'b1, 1'b0, 2'd2, 18'h163C0}, // R5 neg no flag
    {4'd5,  18'h04000, 18'h00000, 1'b1, 1'b0, 2'd3, 18'h23FFF}, // R5 R3 bit14
    {4'd7,  18'h1FFFF, 18'h00001, 1'b1, 1'b0, 2'd0, 18'h20000}, // R7
    {4'd8,  18'h00005, 18'h00000, 1'b0, 1'b1, 2'd0, 18'h20005}, // R8 bit17
    {4'd8,  18'h0EA60, 18'h02710, 1'b1, 1'b1, 2'd1, 18'h3FFFF}, // R8 R6 pos clip
    {4'd8,  18'h315A0, 18'h3D8F0, 1'b1, 1'b1, 2'd1, 18'h20000}, // R8 R6 neg clip
    {4'd9,  18'h00010, 18'h00000, 1'b0, 1'b1, 2'd2, 18'h08010}, // R9 0x08000
    {4'd9,  18'h3FFFF, 18'h00000, 1'b1, 1'b1, 2'd3, 18'h0BFFF}, // R9 0x0C000 wrap
    {4'd9,  18'h08000, 18'h00000, 1'b1, 1'b1, 2'd2, 18'h2FFFF}, // R9 R6 clip kept
    {4'd10, 18'h20000, 18'h20000, 1'b1, 1'b0, 2'd1, 18'h30000}, // R10 -2^18
    {4'd10, 18'h20000, 18'h20000, 1'b0, 1'b0, 2'd1, 18'h00000}  // R10 wrap when off
  };

  task automatic check(input int req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0] c, input logic [17:0] k,
                       input logic ce, input logic oe, input logic [1:0] s);
    carrier_i = c; cascade_i = k; clip_en_i = ce; obin_en_i = oe; map_sel_i = s;
  endtask

  initial begin
    apply(18'h00123, 18'h00456, 1'b0, 1'b0, 2'd0);
    repeat (3) @(negedge clk_i);
    check(1, out_o, 18'h00000); // R1 reset holds zero
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, out_o, 18'h00579); // R1 first sample after reset
    // R1 latency: new inputs not visible before the edge
    apply(18'h00001, 18'h00001, 1'b0, 1'b0, 2'd0);
    #1 check(1, out_o, 18'h00579);
    @(negedge clk_i);
    check(1, out_o, 18'h00002);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][57:40], VEC[i][39:22], VEC[i][21], VEC[i][20], VEC[i][19:18]);
      @(negedge clk_i);
      check(int'(VEC[i][61:58]), out_o, VEC[i][17:0]);
    end

    // R7 directed: clip enable toggled on sel 0 with large negative sum
    apply(18'h20000, 18'h3FFFF, 1'b1, 1'b0, 2'd0);
    @(negedge clk_i);
    check(7, out_o, 18'h1FFFF);
    // R1 async reset clears output
    rst_ni = 1'b0;
    #1 check(1, out_o, 18'h00000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL R1: watchdog expired got %h expected done", out_o);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule